// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one channel of a timer, used in compare mode. It keeps a 16-bit compare value and watches a 16-bit free-running counter that it shares with other channels. When the counter reaches the compare value in a cycle where the counter advances, the channel acts on its output pin. Depending on a two-bit action code, it drives the pin high, drives it low or toggles it. In the same cycle it raises an event flag, and that flag can request an interrupt.

Software makes periodic pulses by rewriting the compare value after each event. This sets the pulse width, the period and, through the action code, the polarity. The compare value is written over an 8-bit bus as two bytes. The high byte is held aside and lands together with the low byte, so the comparator never sees a half-updated value. The counter and its prescaler sit outside this block.

Top module: `oc_channel`

## Requirements
- R1: After reset the pin register, the event flag, the held high byte and the compare value are all 0, and the interrupt output is 0.
- R2: If `cmp_mode` is 1, `tick` is 1 and `count` equals the compare value at a clock edge, `evt_flag` reads 1 after that edge.
- R3: A cycle with `tick` at 0 causes no compare action, even when `count` equals the compare value. The pin register and the flag keep their values, although a clear strobe can still clear the flag.
- R4: On a compare event the action code `act_code` updates the pin register as follows: 2'b01 toggles it, 2'b10 drives it to 0 and 2'b11 drives it to 1.
- R5: With `act_code` at 2'b00, `pin_oe` is 0 and a compare event leaves the pin register unchanged. The flag is still set.
- R6: With `cmp_mode` at 0, `pin_oe` is 0 and no compare event happens: the pin and the flag are not changed by the counter.
- R7: A strobe on `wr_hi` stores `wr_data` as a pending high byte and leaves the active compare value unchanged. A strobe on `wr_lo` loads the compare value as {pending high byte, `wr_data`}. A compare at the same edge as a write uses the old value.
- R8: A 1 on `flag_clr` clears the flag at the next edge, unless a compare event happens at that same edge; in that case the flag stays 1.
- R9: `irq` is 1 exactly when `evt_flag` is 1 and `irq_en` is 1.
- R10: `pin_out` always shows the pin register, and `pin_oe` is 1 exactly when `cmp_mode` is 1 and `act_code` is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Counter advances in this cycle |
| count | input | 16 | Shared free-running counter value |
| wr_hi | input | 1 | Write strobe for the compare high byte |
| wr_lo | input | 1 | Write strobe for the compare low byte; commits all 16 bits |
| wr_data | input | 8 | Bus write data |
| cmp_mode | input | 1 | Channel select: 1 = compare mode |
| act_code | input | 2 | Compare action: 00 released, 01 toggle, 10 clear, 11 set |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one strobe that clears the flag |
| pin_out | output | 1 | Pin register value |
| pin_oe | output | 1 | Compare logic drives the pin |
| evt_flag | output | 1 | Compare event flag |
| irq | output | 1 | Interrupt request |

## Verification
If the compare value or the pending high byte holds a wrong value, a compare event fires on the wrong count. This shows up one edge later on `evt_flag` and, unless the action code is 00, on `pin_out`. A pin register that is wrong shows on `pin_out` at once and stays wrong until the next set or clear event. A stuck or lost flag shows on `evt_flag` and, when `irq_en` is 1, on `irq` in the same cycle. The reference model is compared on every clock, so each fault is caught within one cycle of the first point where it can be seen at the ports.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] count,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [BW-1:0] wr_data,
  input  logic          cmp_mode,
  input  logic [1:0]    act_code,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          evt_flag,
  output logic          irq
);

  localparam int HW = CW - BW;

  logic [HW-1:0] hi_hold;
  logic [CW-1:0] cmp_q;
  logic          pin_q;
  logic          flag_q;
  logic          hit;

  assign hit = cmp_mode && tick && (count == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_hold <= '0;
      cmp_q   <= '0;
    end else begin
      if (wr_hi) hi_hold <= wr_data[HW-1:0];
      if (wr_lo) cmp_q   <= {hi_hold, wr_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (hit) begin
      case (act_code)
        2'b01:   pin_q <= ~pin_q;
        2'b10:   pin_q <= 1'b0;
        2'b11:   pin_q <= 1'b1;
        default: pin_q <= pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (hit)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign pin_out  = pin_q;
  assign pin_oe   = cmp_mode && (act_code != 2'b00);
  assign evt_flag = flag_q;
  assign irq      = flag_q && irq_en;

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [CW-1:0] count,
  input logic [CW-1:0] cmp_q,
  input logic          wr_hi,
  input logic          wr_lo,
  input logic          cmp_mode,
  input logic [1:0]    act_code,
  input logic          irq_en,
  input logic          flag_clr,
  input logic          pin_out,
  input logic          pin_oe,
  input logic          evt_flag,
  input logic          irq
);

  // R2
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && tick && count == cmp_q) |=> evt_flag);

  // R3
  stall_keeps_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pin_out));

  // R3
  stall_no_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !$rose(evt_flag));

  // R4
  toggle_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && tick && count == cmp_q && act_code == 2'b01) |=> (pin_out != $past(pin_out)));

  // R5
  released_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == 2'b00) |-> !pin_oe);

  // R6
  off_mode_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_mode |=> $stable(pin_out));

  // R7
  high_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> $stable(cmp_q));

  // R8
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(cmp_mode && tick && count == cmp_q)) |=> !evt_flag);

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && evt_flag));

endmodule

bind oc_channel oc_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .cmp_q(cmp_q),
  .wr_hi(wr_hi), .wr_lo(wr_lo), .cmp_mode(cmp_mode), .act_code(act_code),
  .irq_en(irq_en), .flag_clr(flag_clr), .pin_out(pin_out), .pin_oe(pin_oe),
  .evt_flag(evt_flag), .irq(irq)
);

// File: tb/test_oc_channel.sv
`timescale 1ns/1ps
module test_oc_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] count = '0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        cmp_mode = 1'b0;
  logic [1:0]  act_code = 2'b00;
  logic        irq_en = 1'b0, flag_clr = 1'b0;
  logic        pin_out, pin_oe, evt_flag, irq;

  int checks = 0, fails = 0;
  string phase = "R1";

  // reference model state
  logic [7:0]  m_hi = '0;
  logic [15:0] m_cmp = '0;
  logic        m_pin = 1'b0, m_flag = 1'b0;

  always #2.5 clk = ~clk;

  oc_channel i_oc_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .cmp_mode(cmp_mode), .act_code(act_code), .irq_en(irq_en),
    .flag_clr(flag_clr), .pin_out(pin_out), .pin_oe(pin_oe),
    .evt_flag(evt_flag), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = '0; m_cmp = '0; m_pin = 1'b0; m_flag = 1'b0;
    end else begin
      bit ev;
      ev = cmp_mode && tick && (count == m_cmp);
      if (ev) begin
        if (act_code == 2'b01) m_pin = !m_pin;
        else if (act_code == 2'b10) m_pin = 1'b0;
        else if (act_code == 2'b11) m_pin = 1'b1;
        m_flag = 1'b1;
      end else if (flag_clr) m_flag = 1'b0;
      if (wr_lo) m_cmp = {m_hi, wr_data};
      if (wr_hi) m_hi = wr_data;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) at %0t: actual=%b expected=%b", tag, phase, $time, act, exp);
    end
  endtask

  // compare all outputs against the model, every cycle
  always @(negedge clk) if (rst_n) begin
    chk("R4 pin_out", pin_out, m_pin);
    chk("R10 pin_oe", pin_oe, cmp_mode && act_code != 2'b00);
    chk("R2 evt_flag", evt_flag, m_flag);
    chk("R9 irq", irq, m_flag && irq_en);
  end

  task automatic idle();
    @(negedge clk);
    tick = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic write_cmp(logic [15:0] v);
    @(negedge clk); wr_hi = 1'b1; wr_lo = 1'b0; wr_data = v[15:8];
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = v[7:0];
    idle();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1; wr_hi = 1'b0; wr_lo = 1'b0; flag_clr = 1'b0;
      count = count + 16'd1;
    end
    idle();
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1; tick = 1'b0;
    idle();
  endtask

  initial begin : watchdog
    #(5ns * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #12 ;
    phase = "R1";
    checks++; if (pin_out !== 1'b0) begin fails++; $display("FAIL R1 pin_out actual=%b expected=0", pin_out); end
    checks++; if (evt_flag !== 1'b0) begin fails++; $display("FAIL R1 evt_flag actual=%b expected=0", evt_flag); end
    checks++; if (irq !== 1'b0) begin fails++; $display("FAIL R1 irq actual=%b expected=0", irq); end
    @(negedge clk); rst_n = 1'b1;

    phase = "R4 toggle";
    cmp_mode = 1'b1; act_code = 2'b01; irq_en = 1'b1;
    write_cmp(16'h0010);
    count = 16'h0008; run(20);
    clear_flag();
    count = 16'h0008; run(20);

    phase = "R3 stall";
    clear_flag();
    @(negedge clk); count = 16'h0010; tick = 1'b0;
    repeat (6) @(negedge clk);
    checks++; if (evt_flag !== 1'b0) begin fails++; $display("FAIL R3 evt_flag actual=%b expected=0", evt_flag); end
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    checks++; if (evt_flag !== 1'b1) begin fails++; $display("FAIL R3 evt_flag actual=%b expected=1", evt_flag); end
    idle();

    phase = "R4 clear";
    act_code = 2'b11; count = 16'h000C; run(8);
    act_code = 2'b10; count = 16'h000C; run(8);
    phase = "R5 released";
    clear_flag();
    act_code = 2'b00; count = 16'h000C; run(8);

    phase = "R7 split write";
    act_code = 2'b01;
    @(negedge clk); wr_hi = 1'b1; wr_data = 8'h12;
    idle(); clear_flag();
    count = 16'h000C; run(8);
    @(negedge clk); wr_lo = 1'b1; wr_data = 8'h34;
    idle(); clear_flag();
    count = 16'h0010; run(8);
    count = 16'h1230; run(8);

    phase = "R8 clear vs event";
    count = 16'h1233; run(1);
    @(negedge clk); count = 16'h1234; tick = 1'b1; flag_clr = 1'b1;
    idle();
    checks++; if (evt_flag !== 1'b1) begin fails++; $display("FAIL R8 evt_flag actual=%b expected=1", evt_flag); end
    clear_flag();
    checks++; if (evt_flag !== 1'b0) begin fails++; $display("FAIL R8 evt_flag actual=%b expected=0", evt_flag); end

    phase = "R6 off";
    cmp_mode = 1'b0; count = 16'h1230; run(8);
    cmp_mode = 1'b1;

    phase = "R9 random";
    write_cmp(16'h0003);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      tick     = ($urandom_range(0, 3) != 0);
      count    = 16'($urandom_range(0, 5));
      cmp_mode = ($urandom_range(0, 7) != 0);
      act_code = 2'($urandom_range(0, 3));
      irq_en   = 1'($urandom_range(0, 1));
      flag_clr = ($urandom_range(0, 5) == 0);
      wr_hi    = ($urandom_range(0, 19) == 0);
      wr_lo    = ($urandom_range(0, 19) == 0);
      wr_data  = wr_hi ? 8'h00 : 8'($urandom_range(0, 5));
    end
    idle(); idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule